// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers up to 32 asynchronous interrupt pins from outside the chip and combines them into one request line for the processor's interrupt controller. Each pin is first brought into the clock domain through a two-stage synchronizer. It is then sensed either on an edge or on a level. Software picks the sense per line with three independent configuration words: one selects edge or level sensing, one selects the edge direction, and one selects the active level.

Software works the block through a 32-bit register port with single-cycle writes and combinational reads.
- Enables are changed with separate set and clear words, so no read-modify-write is needed.
- Pending lines are acknowledged by writing ones to a clear word.
- The number of built lines is a parameter. Every bit above that count reads as zero, so software can find the line count by writing all ones to the mode word and reading it back.

Top module: `extIntCtrl`

## Requirements
- R1: After reset, the mask (0x08), status (0x0C), mode (0x14), edge (0x18) and level (0x1C) words all read zero, and `irqOut` is low.
- R2: A write to 0x00 sets the mask bits where the data has ones. A write to 0x04 clears the mask bits where the data has ones. Reading 0x08 returns the current mask, and a write to 0x08 or 0x0C changes nothing.
- R3: For bit positions at or above `NUM_LINES`, the mask, status, mode, edge and level words read zero, and toggling those input pins never sets status. Writing all ones to 0x14 reads back as 2^NUM_LINES-1.
- R4: When a line's mode bit is 0 and its edge bit is 0, a high-to-low change on its pin sets its status bit. The bit becomes visible on the third rising clock edge after the pin changes, and a low-to-high change sets nothing.
- R5: When a line's mode bit is 0 and its edge bit is 1, a low-to-high change sets its status bit with the same three-edge latency. A high-to-low change sets nothing.
- R6: When a line's mode bit is 1, its status bit follows the synchronized pin. The pin is active when high if the level bit is 1, and active when low if the level bit is 0. A write to the clear word at 0x10 cannot remove the bit while the pin stays active.
- R7: For an edge-sensed line, writing 1 to its bit at 0x10 clears its status bit. Bits written as 0 leave status unchanged.
- R8: If an edge detection and a clear write for the same line fall in the same clock cycle, the detection wins and the status bit stays set.
- R9: Status bits are set whether or not the line is enabled. `irqOut` is high exactly when some status bit and its mask bit are both 1.
- R10: The test word (0x20) stores only bit 31, and the non-maskable-control word (0x24) stores only bit 0. All other bits of these words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | 8 | Byte offset of the accessed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data at `regAddr` |
| extIn | input | 32 | External interrupt pins, asynchronous |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Two events can land on one status bit in the same cycle: a software acknowledge and a freshly detected edge. The bench sets this up on purpose. It drops a pin, waits exactly two clock edges, and then issues the clear write, so that both are sampled on the third edge. It then expects the line to stay pending. The random phase throws clear writes at random lines while pins toggle under mixed edge and level configurations. Each cycle it compares status and `irqOut` against a bench model built from the requirements.

// File: rtl/extIntPkg.sv
package extIntPkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_EN_SET = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EDGE   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_TEST   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_NMI    = 8'h24;

  localparam int TEST_BIT = 31;
  localparam int NMI_BIT  = 0;

  // one-cycle write strobes from the decoder to the datapath
  typedef struct packed {
    logic enSet;
    logic enClr;
    logic ack;
    logic wrMode;
    logic wrEdge;
    logic wrLevel;
    logic wrTest;
    logic wrNmi;
  } strobes_t;
endpackage

// File: rtl/extIntCtrlUnit.sv
module extIntCtrlUnit
  import extIntPkg::*;
(
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] maskQ,
  input  logic [DATA_W-1:0] statusQ,
  input  logic [DATA_W-1:0] modeQ,
  input  logic [DATA_W-1:0] edgeQ,
  input  logic [DATA_W-1:0] levelQ,
  input  logic              testQ,
  input  logic              nmiQ,
  output strobes_t          stb,
  output logic [DATA_W-1:0] regRdData
);
  always_comb begin
    stb         = '0;
    stb.enSet   = regWr && (regAddr == OFS_EN_SET);
    stb.enClr   = regWr && (regAddr == OFS_EN_CLR);
    stb.ack     = regWr && (regAddr == OFS_ACK);
    stb.wrMode  = regWr && (regAddr == OFS_MODE);
    stb.wrEdge  = regWr && (regAddr == OFS_EDGE);
    stb.wrLevel = regWr && (regAddr == OFS_LEVEL);
    stb.wrTest  = regWr && (regAddr == OFS_TEST);
    stb.wrNmi   = regWr && (regAddr == OFS_NMI);
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_MASK:   regRdData = maskQ;
      OFS_STATUS: regRdData = statusQ;
      OFS_MODE:   regRdData = modeQ;
      OFS_EDGE:   regRdData = edgeQ;
      OFS_LEVEL:  regRdData = levelQ;
      OFS_TEST:   regRdData[TEST_BIT] = testQ;
      OFS_NMI:    regRdData[NMI_BIT] = nmiQ;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/extIntDatapath.sv
module extIntDatapath
  import extIntPkg::*;
#(
  parameter int NUM_LINES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] extIn,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] modeQ,
  output logic [DATA_W-1:0] edgeQ,
  output logic [DATA_W-1:0] levelQ,
  output logic              testQ,
  output logic              nmiQ,
  output logic              irqOut
);
  localparam logic [DATA_W:0]   IMPL_W = (({{DATA_W{1'b0}}, 1'b1}) << NUM_LINES) - 1'b1;
  localparam logic [DATA_W-1:0] IMPL   = IMPL_W[DATA_W-1:0];

  logic [DATA_W-1:0] ackVec;
  assign ackVec = stb.ack ? wrData : '0;

  // pins above the implemented count are deliberately left unconnected
  logic unusedIn;
  assign unusedIn = ^(extIn & ~IMPL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      modeQ  <= '0;
      edgeQ  <= '0;
      levelQ <= '0;
      testQ  <= 1'b0;
      nmiQ   <= 1'b0;
    end else begin
      if (stb.enSet)      maskQ <= maskQ | (wrData & IMPL);
      else if (stb.enClr) maskQ <= maskQ & ~wrData;
      if (stb.wrMode)  modeQ  <= wrData & IMPL;
      if (stb.wrEdge)  edgeQ  <= wrData & IMPL;
      if (stb.wrLevel) levelQ <= wrData & IMPL;
      if (stb.wrTest)  testQ  <= wrData[TEST_BIT];
      if (stb.wrNmi)   nmiQ   <= wrData[NMI_BIT];
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_line
    if (i < NUM_LINES) begin : g_impl
      logic syncA, syncB, prevQ, pendQ;
      logic rise, fall, edgeHit, levelHit;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA <= 1'b0;
          syncB <= 1'b0;
          prevQ <= 1'b0;
        end else begin
          syncA <= extIn[i];
          syncB <= syncA;
          prevQ <= syncB;
        end
      end

      assign rise     = syncB & ~prevQ;
      assign fall     = ~syncB & prevQ;
      assign edgeHit  = edgeQ[i] ? rise : fall;
      assign levelHit = levelQ[i] ? syncB : ~syncB;

      // detection has priority over a concurrent acknowledge
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         pendQ <= 1'b0;
        else if (modeQ[i]) pendQ <= levelHit;
        else               pendQ <= edgeHit | (pendQ & ~ackVec[i]);
      end

      assign statusQ[i] = pendQ;
    end else begin : g_none
      assign statusQ[i] = 1'b0;
    end
  end

  assign irqOut = |(statusQ & maskQ);
endmodule

// File: rtl/extIntCtrl.sv
module extIntCtrl
  import extIntPkg::*;
#(
  parameter int NUM_LINES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [31:0] extIn,
  output logic        irqOut
);
  strobes_t          stb;
  logic [DATA_W-1:0] maskQ, statusQ, modeQ, edgeQ, levelQ;
  logic              testQ, nmiQ;

  extIntCtrlUnit i_ctrl (
    .regWr    (regWr),
    .regAddr  (regAddr),
    .maskQ    (maskQ),
    .statusQ  (statusQ),
    .modeQ    (modeQ),
    .edgeQ    (edgeQ),
    .levelQ   (levelQ),
    .testQ    (testQ),
    .nmiQ     (nmiQ),
    .stb      (stb),
    .regRdData(regRdData)
  );

  extIntDatapath #(.NUM_LINES(NUM_LINES)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (regWrData),
    .extIn  (extIn),
    .maskQ  (maskQ),
    .statusQ(statusQ),
    .modeQ  (modeQ),
    .edgeQ  (edgeQ),
    .levelQ (levelQ),
    .testQ  (testQ),
    .nmiQ   (nmiQ),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/extIntChecker.sv
module extIntChecker
  import extIntPkg::*;
#(
  parameter int NUM_LINES = 20
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic [7:0]  regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] maskQ,
  input logic [31:0] statusQ
);
  localparam logic [32:0] IMPL_W = (33'd1 << NUM_LINES) - 33'd1;
  localparam logic [31:0] IMPL   = IMPL_W[31:0];

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == OFS_EN_SET) |=>
      ((maskQ & $past(regWrData) & IMPL) == ($past(regWrData) & IMPL)));

  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == OFS_EN_CLR) |=> ((maskQ & $past(regWrData)) == '0));

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && (regAddr == OFS_EN_SET || regAddr == OFS_EN_CLR)) |=> $stable(maskQ));

  // R3
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ | maskQ) & ~IMPL) == '0);
endmodule

bind extIntCtrl extIntChecker #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .maskQ    (maskQ),
  .statusQ  (statusQ)
);

// File: tb/test_extIntCtrl.sv
module test_extIntCtrl;
  import extIntPkg::*;

  localparam int          N    = 20;
  localparam logic [31:0] IMPL = 32'h000F_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = OFS_STATUS;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] extIn = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  extIntCtrl #(.NUM_LINES(N)) i_extIntCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .extIn(extIn), .irqOut(irqOut)
  );

  // reference model built from the requirements
  logic [31:0] mA, mB, mP, mStat, mMode, mEdge, mLevel, mMask;

  function automatic logic [31:0] nextStat(input logic [31:0] st, b, p, md, ed, lv, ack);
    logic [31:0] eh, lh;
    eh = (ed & b & ~p) | (~ed & ~b & p);
    lh = (lv & b) | (~lv & ~b);
    return ((md & lh) | (~md & ((st & ~ack) | eh))) & IMPL;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mA <= '0; mB <= '0; mP <= '0; mStat <= '0;
      mMode <= '0; mEdge <= '0; mLevel <= '0; mMask <= '0;
    end else begin
      mA <= extIn; mB <= mA; mP <= mB;
      mStat <= nextStat(mStat, mB, mP, mMode, mEdge, mLevel,
                        (regWr && regAddr == OFS_ACK) ? regWrData : 32'h0);
      if (regWr) begin
        case (regAddr)
          OFS_EN_SET: mMask  <= mMask | (regWrData & IMPL);
          OFS_EN_CLR: mMask  <= mMask & ~regWrData;
          OFS_MODE:   mMode  <= regWrData & IMPL;
          OFS_EDGE:   mEdge  <= regWrData & IMPL;
          OFS_LEVEL:  mLevel <= regWrData & IMPL;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expectReg(input string tag, input logic [7:0] a, input logic [31:0] e);
    regAddr = a;
    #1;
    check(tag, regRdData, e);
  endtask

  task automatic expectIrq(input string tag, input logic e);
    #1;
    check(tag, {31'b0, irqOut}, {31'b0, e});
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = OFS_STATUS; regWrData = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(2);
    rstN = 1'b1;
    cyc(1);

    // R1 reset state
    expectReg("R1 mask", OFS_MASK, 32'h0);
    expectReg("R1 status", OFS_STATUS, 32'h0);
    expectReg("R1 mode", OFS_MODE, 32'h0);
    expectReg("R1 edge", OFS_EDGE, 32'h0);
    expectReg("R1 level", OFS_LEVEL, 32'h0);
    expectIrq("R1 irq", 1'b0);

    // R3 line-count probe
    wrReg(OFS_MODE, 32'hFFFF_FFFF);
    expectReg("R3 mode probe", OFS_MODE, IMPL);
    wrReg(OFS_MODE, 32'h0);
    wrReg(OFS_ACK, 32'hFFFF_FFFF);
    expectReg("R3 status after cleanup", OFS_STATUS, 32'h0);

    // R2 enable set/clear
    wrReg(OFS_EN_SET, 32'h0000_0005);
    expectReg("R2 set", OFS_MASK, 32'h0000_0005);
    wrReg(OFS_EN_SET, 32'h0000_0010);
    expectReg("R2 set accumulates", OFS_MASK, 32'h0000_0015);
    wrReg(OFS_EN_CLR, 32'h0000_0004);
    expectReg("R2 clear", OFS_MASK, 32'h0000_0011);
    wrReg(OFS_MASK, 32'h0000_FFFF);
    expectReg("R2 mask write ignored", OFS_MASK, 32'h0000_0011);
    wrReg(OFS_STATUS, 32'h0000_FFFF);
    expectReg("R2 status write ignored", OFS_STATUS, 32'h0);
    wrReg(OFS_EN_SET, 32'hFFFF_FFFF);
    expectReg("R3 mask upper zero", OFS_MASK, IMPL);
    wrReg(OFS_EN_CLR, 32'hFFFF_FFFF);
    expectReg("R2 clear all", OFS_MASK, 32'h0);

    // R4 default falling edge, latency of three edges
    extIn[3] = 1'b1;
    cyc(4);
    expectReg("R4 rising ignored", OFS_STATUS, 32'h0);
    extIn[3] = 1'b0;
    cyc(2);
    expectReg("R4 not yet", OFS_STATUS, 32'h0);
    cyc(1);
    expectReg("R4 falling sets", OFS_STATUS, 32'h0000_0008);

    // R9 masking gates only the output
    expectIrq("R9 masked irq low", 1'b0);
    wrReg(OFS_EN_SET, 32'h0000_0008);
    expectIrq("R9 enabled irq high", 1'b1);
    // R7 acknowledge
    wrReg(OFS_ACK, 32'h0);
    expectReg("R7 zero ack no effect", OFS_STATUS, 32'h0000_0008);
    wrReg(OFS_ACK, 32'h0000_0008);
    expectReg("R7 ack clears", OFS_STATUS, 32'h0);
    expectIrq("R7 irq drops", 1'b0);
    wrReg(OFS_EN_CLR, 32'hFFFF_FFFF);

    // R5 rising edge
    wrReg(OFS_EDGE, 32'h0000_0010);
    extIn[4] = 1'b1;
    cyc(3);
    expectReg("R5 rising sets", OFS_STATUS, 32'h0000_0010);
    wrReg(OFS_ACK, 32'h0000_0010);
    extIn[4] = 1'b0;
    cyc(4);
    expectReg("R5 falling ignored", OFS_STATUS, 32'h0);

    // R6 level active-high
    wrReg(OFS_LEVEL, 32'h0000_0020);
    wrReg(OFS_MODE, 32'h0000_0020);
    cyc(1);
    expectReg("R6 inactive level", OFS_STATUS, 32'h0);
    extIn[5] = 1'b1;
    cyc(3);
    expectReg("R6 high asserts", OFS_STATUS, 32'h0000_0020);
    wrReg(OFS_ACK, 32'h0000_0020);
    expectReg("R6 ack ignored while active", OFS_STATUS, 32'h0000_0020);
    extIn[5] = 1'b0;
    cyc(2);
    expectReg("R6 still held", OFS_STATUS, 32'h0000_0020);
    cyc(1);
    expectReg("R6 follows release", OFS_STATUS, 32'h0);
    // R6 level active-low
    wrReg(OFS_MODE, 32'h0000_0060);
    cyc(1);
    expectReg("R6 low asserts", OFS_STATUS, 32'h0000_0040);
    extIn[6] = 1'b1;
    cyc(3);
    expectReg("R6 low released", OFS_STATUS, 32'h0);
    wrReg(OFS_MODE, 32'h0);

    // R3 pins above line count
    extIn[25] = 1'b1;
    cyc(4);
    extIn[25] = 1'b0;
    cyc(4);
    expectReg("R3 unimplemented pin", OFS_STATUS, 32'h0);

    // R8 detection and ack in the same cycle
    extIn[7] = 1'b1;
    cyc(4);
    extIn[7] = 1'b0;
    cyc(3);
    expectReg("R8 first edge", OFS_STATUS, 32'h0000_0080);
    extIn[7] = 1'b1;
    cyc(4);
    extIn[7] = 1'b0;
    cyc(2);
    regWr = 1'b1; regAddr = OFS_ACK; regWrData = 32'h0000_0080;
    @(negedge clk);
    regWr = 1'b0; regAddr = OFS_STATUS; regWrData = '0;
    expectReg("R8 detection wins", OFS_STATUS, 32'h0000_0080);
    wrReg(OFS_ACK, 32'h0000_0080);
    expectReg("R8 later ack clears", OFS_STATUS, 32'h0);

    // R10 test and non-maskable control words
    wrReg(OFS_TEST, 32'hFFFF_FFFF);
    expectReg("R10 test bit", OFS_TEST, 32'h8000_0000);
    wrReg(OFS_NMI, 32'hFFFF_FFFF);
    expectReg("R10 nmi bit", OFS_NMI, 32'h0000_0001);
    wrReg(OFS_NMI, 32'hFFFF_FFFE);
    expectReg("R10 nmi cleared", OFS_NMI, 32'h0);

    // random phase against the model
    for (int round = 0; round < 3; round++) begin
      @(negedge clk);
      extIn = '0;
      rstN = 1'b0;
      cyc(2);
      rstN = 1'b1;
      wrReg(OFS_MODE, $urandom);
      wrReg(OFS_EDGE, $urandom);
      wrReg(OFS_LEVEL, $urandom);
      wrReg(OFS_EN_SET, $urandom);
      for (int c = 0; c < 400; c++) begin
        @(negedge clk);
        #2;
        if (!regWr) begin
          check("R4 R5 R6 R7 R8 random status", regRdData, mStat);
          check("R9 random irq", {31'b0, irqOut}, {31'b0, |(mStat & mMask)});
        end
        extIn = extIn ^ ($urandom & $urandom & $urandom);
        if ($urandom_range(3) == 0) begin
          regWr = 1'b1; regAddr = OFS_ACK; regWrData = $urandom;
        end else begin
          regWr = 1'b0; regAddr = OFS_STATUS; regWrData = '0;
        end
      end
      @(negedge clk);
      regWr = 1'b0; regAddr = OFS_STATUS; regWrData = '0;
    end

    finishRun();
  end
endmodule